// File: doc/BRIEF.md
# Local Pause Transmit-Halt Timer

This block holds the transmit queues off for a programmed stretch of time when software calls for a local pause. No received pause frame is needed. Software writes a 16-bit pause length, counted in quanta, into one control word. Setting a trigger bit in the same write starts the pause at once.

A single-cycle bit-time enable paces the timer. Every 512 enables make one quantum. The halt output stays high while whole quanta remain.

The control word reads back the stored length. The trigger bit and the unused upper bits always read as zero. When a new trigger arrives during a pause, the timer reloads the full length and restarts its timing.

Top module: `pause_halt_timer`

## Requirements
- R1: After reset, halt_o is low and the control word reads 0x0000_0000.
- R2: A write stores bits 15:0 as the pause length. Reads return the length in bits 15:0 and zero in bits 31:16. Both the trigger bit 16 and the reserved bits 31:17 always read 0.
- R3: A write with bit 16 set and a nonzero length in bits 15:0 raises halt_o in the cycle after the write.
- R4: With length N, halt_o stays high through exactly N*512 - 1 bit-time enables after the start. It is low after the N*512-th enable.
- R5: A start with length zero leaves halt_o low.
- R6: A write with bit 16 clear changes the stored length but has no effect on a pause already running.
- R7: A start during an active pause reloads the full new length and clears the partial quantum. Timing then begins again from zero.
- R8: Bit-time enables that arrive while no pause is active are ignored. A later pause still lasts its full duration.
- R9: A bit-time enable in the same cycle as a start write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Write data: length in 15:0, start trigger in bit 16 |
| rd_data_o | output | 32 | Control word readback |
| bit_tick_i | input | 1 | One-cycle enable per receive bit time |
| halt_o | output | 1 | Holds the transmit queues while high |

## Verification
A corrupted quanta counter shows up as a wrong fall time of halt_o. A counter that is off by one quantum moves the fall by 512 enables. Because of this, the checks sample halt_o exactly one enable before and one enable after the expected end of each pause.

A sub-counter that is not cleared on a start, or that advances while idle, shifts the fall by up to 511 enables. Restart, idle-enable and same-cycle cases expose this within a single pause. A stored length that is wrong appears in the readback in the cycle after the write.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int DATA_W       = 32;
  localparam int LEN_W        = 16;
  localparam int START_POS    = 16;
  localparam int QUANTUM_LOG2 = 9;
  typedef logic [LEN_W-1:0] len_t;
endpackage

// File: rtl/pause_cfg_reg.sv
module pause_cfg_reg #(
  parameter int DATA_W    = pause_pkg::DATA_W,
  parameter int LEN_W     = pause_pkg::LEN_W,
  parameter int START_POS = pause_pkg::START_POS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              start_o,
  output logic [LEN_W-1:0]  load_len_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int PAD_W = DATA_W - LEN_W;

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (wr_en_i) len_q <= wr_data_i[LEN_W-1:0];
  end

  // trigger is a pulse; the length loaded is the one written alongside it
  assign start_o    = wr_en_i & wr_data_i[START_POS];
  assign load_len_o = wr_data_i[LEN_W-1:0];
  assign rd_data_o  = {{PAD_W{1'b0}}, len_q};

  AST_LEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o)); // R2
endmodule

// File: rtl/pause_quanta_cnt.sv
module pause_quanta_cnt #(
  parameter int LEN_W = pause_pkg::LEN_W,
  parameter int SUB_W = pause_pkg::QUANTUM_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] load_i,
  input  logic             tick_i,
  output logic             halt_o
);
  localparam logic [SUB_W-1:0] SUB_LAST = {SUB_W{1'b1}};

  logic [LEN_W-1:0] cnt_q;
  logic [SUB_W-1:0] sub_q;
  logic             active;

  assign active = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sub_q <= '0;
    end else if (start_i) begin
      cnt_q <= load_i;
      sub_q <= '0;
    end else if (active && tick_i) begin
      sub_q <= sub_q + 1'b1;
      if (sub_q == SUB_LAST) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign halt_o = active;

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == $past(load_i)); // R7
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && active) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - LEN_W'(1))); // R4
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !active) |=> (cnt_q == '0) && (sub_q == '0)); // R8
  AST_TICK_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> sub_q == '0); // R9
endmodule

// File: rtl/pause_halt_timer.sv
module pause_halt_timer
  import pause_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LEN_W,
  parameter int SP = START_POS,
  parameter int QL = QUANTUM_LOG2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          bit_tick_i,
  output logic          halt_o
);
  logic          start;
  logic [LW-1:0] load_len;

  pause_cfg_reg #(.DATA_W(DW), .LEN_W(LW), .START_POS(SP)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .start_o    (start),
    .load_len_o (load_len),
    .rd_data_o  (rd_data_o)
  );

  pause_quanta_cnt #(.LEN_W(LW), .SUB_W(QL)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .load_i  (load_len),
    .tick_i  (bit_tick_i),
    .halt_o  (halt_o)
  );

  AST_HALT_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[SP] && wr_data_i[LW-1:0] != '0) |=> halt_o); // R3
  AST_ZERO_NO_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[SP] && wr_data_i[LW-1:0] == '0) |=> !halt_o); // R5
  AST_START_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DW-1:LW] == '0); // R2
endmodule

// File: tb/sim_pause_halt_timer.sv
module sim_pause_halt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick = 1'b0;
  logic        halt;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pause_halt_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .bit_tick_i(tick), .halt_o(halt)
  );

  // length, enables after start, expected halt  (R3 R4 R5)
  localparam int NV = 8;
  localparam int V_LEN  [NV] = '{1,   1,   2,    2,    3,    3,    0, 65535};
  localparam int V_TICK [NV] = '{511, 512, 1023, 1024, 1535, 1536, 0, 5000};
  localparam int V_HALT [NV] = '{1,   0,   1,    0,    1,    0,    0, 1};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d, logic t = 1'b0);
    @(negedge clk); wr_en = 1'b1; wr_data = d; tick = t;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 halt", {31'b0, halt}, 32'h0);
    check("R1 rd", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wr(32'h0001_0000 | 32'(V_LEN[v]));
      if (V_TICK[v] == 0) check("R5 zero length", {31'b0, halt}, 32'h0);
      else begin
        ticks(V_TICK[v]);
        check("R4 table", {31'b0, halt}, 32'(V_HALT[v]));
      end
    end

    // R2 readback, trigger and reserved bits read 0
    wr(32'hFFFE_A5A5);
    check("R2 rd", rd_data, 32'h0000_A5A5);
    wr(32'h0001_0002);
    check("R2 rd start", rd_data, 32'h0000_0002);
    check("R3 halt next cycle", {31'b0, halt}, 32'h1);
    // R6 plain write mid-pause has no effect
    ticks(100);
    wr(32'h0000_0005);
    ticks(923);
    check("R6 still halted", {31'b0, halt}, 32'h1);
    ticks(1);
    check("R6 ends at 1024", {31'b0, halt}, 32'h0);
    check("R6 length kept", rd_data, 32'h0000_0005);

    // R7 restart reloads
    wr(32'h0001_0001);
    ticks(300);
    wr(32'h0001_0001);
    ticks(511);
    check("R7 restarted", {31'b0, halt}, 32'h1);
    ticks(1);
    check("R7 end", {31'b0, halt}, 32'h0);

    // R8 idle enables ignored
    ticks(200);
    check("R8 idle", {31'b0, halt}, 32'h0);
    wr(32'h0001_0001);
    ticks(511);
    check("R8 full pause", {31'b0, halt}, 32'h1);
    ticks(1);
    check("R8 end", {31'b0, halt}, 32'h0);

    // R9 enable coincident with start is not counted
    wr(32'h0001_0001, 1'b1);
    ticks(511);
    check("R9 same-cycle", {31'b0, halt}, 32'h1);
    ticks(1);
    check("R9 end", {31'b0, halt}, 32'h0);

    // R1 async reset mid-pause
    wr(32'h0001_0004);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset halt", {31'b0, halt}, 32'h0);
    check("R1 reset rd", rd_data, 32'h0);
    finish_up();
  end
endmodule